// File: doc/BRIEF.md
# Selectable Interrupt Line Driver

This block places a single internal interrupt request onto one of eight shared bus interrupt lines. A 3-bit selection chooses the line. The selection typically comes from a strap value captured at reset in jumper mode, or from a configuration field. Only the chosen line has its output enable set. That line is driven high while the request is asserted and low while it is not. The other seven lines are left floating, so other adapters on the bus can use them.

The same eight lines are also read back as inputs. Their levels pass through a two-stage synchronizer and are presented as an 8-bit status value. Software can read this value to find a line that another device is already holding, and so detect an interrupt conflict before it chooses a line.

Line indices map to bus interrupt numbers as follows: index 0 is IRQ2/9, 1 is IRQ3, 2 is IRQ4, 3 is IRQ5, 4 is IRQ10, 5 is IRQ11, 6 is IRQ12 and 7 is IRQ15.

Top module: `irq_line_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers clear. After that edge, `pin_oe` is 8'b0000_0001 (line 0), `pin_out` is 0 and `line_status` is 0, whatever the level of `pin_in`.
- R2: After reset, exactly one bit of `pin_oe` is set in every cycle, including the cycles in which the selection changes.
- R3: After each clock edge, `pin_oe` is one-hot with bit i set, where i is the value of `line_sel` sampled at that edge. A change of `line_sel` between edges has no effect on `pin_oe` until the next edge.
- R4: After each clock edge, `pin_out` at the enabled bit equals `irq_req` sampled at that edge: 1 for an asserted request and 0 for an idle one.
- R5: Every bit of `pin_out` whose `pin_oe` bit is 0 reads 0.
- R6: `line_status[i]` equals `pin_in[i]` as sampled two clock edges earlier. A new level appears after the second edge, not after the first.
- R7: `line_status` reports all eight lines, and this does not depend on `line_sel` or `irq_req`. A line held high by another device while a different line is selected shows as 1. The line that is selected reads back the level of the bus, not the level the block drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Internal interrupt request, active high |
| line_sel | input | 3 | Index of the line to drive (0 = IRQ2/9 up to 7 = IRQ15) |
| pin_in | input | 8 | Levels sampled from the eight bus lines |
| pin_oe | output | 8 | Output enable per line, one-hot |
| pin_out | output | 8 | Value driven per line when enabled |
| line_status | output | 8 | Synchronized bus line levels |

## Verification
The hardest case to reach from the ports is a change of selection. At that moment the old enable must drop on the same edge that the new one rises, with no cycle in which two lines are enabled or none is. The bench changes `line_sel` on every cycle while the request is held asserted, and it counts the enables after each edge. A second case needs a conflict. The bench drives a line as another adapter would while the block drives a different line, and checks that the status shows the foreign line and the bus level rather than the block's own drive.

// File: rtl/irq_route_pkg.sv
// Package: shared constants for the interrupt line router.
// Assumes: the bus offers eight lines and the input synchronizer uses two flops.
package irq_route_pkg;
    localparam int unsigned IRQ_LINES_DEF = 8;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // One-hot vector for line 0, used as the reset selection.
    function automatic logic [IRQ_LINES_DEF-1:0] first_line();
        return IRQ_LINES_DEF'(1);
    endfunction
endpackage

// File: rtl/irq_sel_decode.sv
// Module: registered one-hot decode of the line selection.
// Assumes: sel is an index below NUM_LINES. Each bit is a plain flop, so the
// old enable and the new enable change on the same edge.
module irq_sel_decode #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    output logic [NUM_LINES-1:0] oe_q
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        // Purpose: per-line enable flop, set only when this line is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) oe_q[i] <= (i == 0);
            else        oe_q[i] <= (sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/irq_pin_drive.sv
// Module: registers the request and forms the per-line output value.
// Assumes: oe is one-hot. A disabled line presents 0 on its value output.
module irq_pin_drive #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [NUM_LINES-1:0] oe,
    output logic [NUM_LINES-1:0] pin_out
);
    logic req_q;

    // Purpose: capture the request so that its timing matches the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
        // Purpose: drive the request level only on the enabled line.
        assign pin_out[i] = oe[i] & req_q;
    end
endmodule

// File: rtl/irq_level_sync.sv
// Module: multi-flop synchronizer for the sampled bus line levels.
// Assumes: the lines are asynchronous to clk and each is treated as an
// independent bit. STAGES is at least 1.
module irq_level_sync #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] d,
    output logic [NUM_LINES-1:0] q
);
    logic [NUM_LINES-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the raw line levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Purpose: later stage that resolves metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_line_router.sv
// Module: top of the selectable interrupt line driver.
// Drives one selected bus interrupt line with the internal request, leaves
// the others floating, and reports the synchronized levels of all lines.
// Assumes: the pad ring combines pin_oe and pin_out into tri-state buffers.
module irq_line_router #(
    parameter int unsigned NUM_LINES  = irq_route_pkg::IRQ_LINES_DEF,
    parameter int unsigned SYNC_DEPTH = irq_route_pkg::SYNC_DEPTH_DEF,
    localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_req,
    input  logic [SEL_W-1:0]     line_sel,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] line_status
);
    // Purpose: the selection becomes a registered one-hot enable.
    irq_sel_decode #(.NUM_LINES(NUM_LINES)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (line_sel),
        .oe_q  (pin_oe)
    );

    // Purpose: the request is driven onto the enabled line.
    irq_pin_drive #(.NUM_LINES(NUM_LINES)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .oe      (pin_oe),
        .pin_out (pin_out)
    );

    // Purpose: the line levels are read back for conflict detection.
    irq_level_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (line_status)
    );
endmodule

// File: rtl/irq_line_router_chk.sv
// Module: assertion checker bound to irq_line_router.
// Assumes: the default two-stage synchronizer depth.
module irq_line_router_chk #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_req,
    input logic [SEL_W-1:0]     line_sel,
    input logic [NUM_LINES-1:0] pin_in,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] line_status
);
    logic warm1, warm2;

    // Purpose: count the out-of-reset edges so that $past values are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm1 <= 1'b0;
            warm2 <= 1'b0;
        end else begin
            warm1 <= 1'b1;
            warm2 <= warm1;
        end
    end

    // R2
    p_single_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warm1 |-> $countones(pin_oe) == 1);

    // R3
    p_sel_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warm1 |-> pin_oe == (NUM_LINES'(1) << $past(line_sel)));

    // R4
    p_req_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        warm1 |-> (pin_out & pin_oe) == (pin_oe & {NUM_LINES{$past(irq_req)}}));

    // R5
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm1 |-> (pin_out & ~pin_oe) == '0);

    // R6, R7
    p_status_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm2 |-> line_status == $past(pin_in, 2));
endmodule

bind irq_line_router irq_line_router_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .line_sel    (line_sel),
    .pin_in      (pin_in),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .line_status (line_status)
);

// File: tb/irq_line_router_tb_top.sv
// Directed bench for irq_line_router. Inputs change on the falling edge and
// outputs are checked on a later falling edge.
module irq_line_router_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_req = 1'b0;
    logic [2:0] line_sel = 3'd0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out, line_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_line_router dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .line_sel    (line_sel),
        .pin_in      (pin_in),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out),
        .line_status (line_status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pin_in = 8'hFF;
        irq_req = 1'b1;
        line_sel = 3'd5;
        repeat (3) @(negedge clk);
        chk("R1 oe", pin_oe, 8'b0000_0001);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 status", line_status, 8'h00);
        rst_n = 1'b1;
        irq_req = 1'b0;
        line_sel = 3'd0;
        pin_in = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_sweep();
        for (int s = 0; s < 8; s++) begin
            line_sel = 3'(s);
            irq_req = 1'b1;
            @(negedge clk);
            chk("R3 sweep oe", pin_oe, 8'(1) << s);
            chk("R4 sweep out", pin_out, 8'(1) << s);
            chk("R5 idle lines", pin_out & ~pin_oe, 8'h00);
        end
    endtask

    task automatic t_request();
        line_sel = 3'd5;
        irq_req = 1'b0;
        @(negedge clk);
        chk("R4 idle drives low", pin_out, 8'h00);
        chk("R4 idle still enabled", pin_oe, 8'b0010_0000);
        irq_req = 1'b1;
        @(negedge clk);
        chk("R4 request high", pin_out, 8'b0010_0000);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R4 request drop", pin_out, 8'h00);
    endtask

    task automatic t_edge_only();
        line_sel = 3'd1;
        @(negedge clk);
        line_sel = 3'd6;
        #2;
        chk("R3 no change before edge", pin_oe, 8'b0000_0010);
        @(negedge clk);
        chk("R3 change after edge", pin_oe, 8'b0100_0000);
    endtask

    task automatic t_switch();
        irq_req = 1'b1;
        for (int k = 0; k < 16; k++) begin
            line_sel = 3'((k * 5 + 3) % 8);
            @(negedge clk);
            chk("R2 one enable", 8'($countones(pin_oe)), 8'd1);
            chk("R2 enable matches", pin_oe, 8'(1) << ((k * 5 + 3) % 8));
        end
        irq_req = 1'b0;
    endtask

    task automatic t_status();
        logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
        logic [7:0] prev;
        prev = line_status;
        foreach (pats[k]) begin
            pin_in = pats[k];
            @(negedge clk);
            chk("R6 not after one edge", line_status, prev);
            @(negedge clk);
            chk("R6 after two edges", line_status, pats[k]);
            prev = pats[k];
        end
    endtask

    task automatic t_conflict();
        line_sel = 3'd2;
        irq_req = 1'b1;
        pin_in = 8'b1000_0100;
        repeat (2) @(negedge clk);
        chk("R7 foreign line seen", line_status, 8'b1000_0100);
        chk("R7 own drive active", pin_out, 8'b0000_0100);
        pin_in = 8'b0000_0000;
        repeat (2) @(negedge clk);
        chk("R7 bus level not own drive", line_status, 8'h00);
        irq_req = 1'b0;
        line_sel = 3'd7;
        pin_in = 8'b0001_0000;
        repeat (2) @(negedge clk);
        chk("R7 independent of select", line_status, 8'b0001_0000);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_request();
        t_edge_only();
        t_switch();
        t_status();
        t_conflict();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule